// File: doc/BRIEF.md
# UART FIFO Threshold Interrupt Unit

This block sits between a UART's serial shifters and its CPU-facing register bank. It keeps a 64-entry receive FIFO and a 64-entry transmit FIFO. Every received byte is stored together with its parity, framing and break flags. From the fill levels, the error tags and a character timer, it works out which interrupt sources are pending. It reports the most urgent one as a 4-bit identity code and drives a single interrupt line.

The receive shifter pushes bytes with their error flags, and the CPU pops them. The CPU pushes transmit bytes, and the transmit shifter pops them. Trigger-level selects and enable bits come from an external register bank. Both FIFOs are fall-through: the head entry is always visible on the data outputs.

Top module: `uart_fifo_irq`

## Requirements
- R1: Each FIFO holds up to 64 bytes. Full is set after 64 accepted pushes with no pop. Empty is set when the stored count is zero. After reset both FIFOs are empty, `overrun` and `err_any` are 0, and `irq_idle` is 1.
- R2: A push into a full receive FIFO is dropped, and `overrun` is set on the next cycle. `overrun` clears on an accepted receive pop, unless a dropped push happens in the same cycle, in which case it stays set.
- R3: A push into a full transmit FIFO is ignored: the stored bytes and their order do not change.
- R4: The receive threshold is pending when the receive count is at least the level chosen by `rx_trig_sel`. The codes are 0=1, 1=8, 2=16, 3=56 and 4=60, and codes 5 to 7 select 8.
- R5: The transmit threshold is pending when the free space in the transmit FIFO is at least the level chosen by `tx_trig_sel`. The codes are 0=1, 1=8, 2=16, 3=32 and 4=56, and codes 5 to 7 select 8.
- R6: `err_any` is 1 exactly while at least one stored receive byte carries a parity, framing or break flag, wherever that byte sits in the FIFO.
- R7: Bytes leave each FIFO in arrival order. `rx_head_pe`, `rx_head_fe` and `rx_head_brk` give the flags of the byte shown on `rx_dout`.
- R8: The character timeout is pending when the receive FIFO is non-empty and `4*CHAR_CYCLES` clock cycles have passed with no accepted receive push or pop. An accepted push or pop restarts the timer.
- R9: Each source is gated by its enable. The line source is gated by `en_line` and is pending on `err_any` or `overrun`. The threshold and timeout sources are gated by `en_rx`, the transmit threshold by `en_tx`, and the modem source (`modem_req`) by `en_modem`. `irq_id` shows the highest pending source. The order and codes are: line 3, receive threshold 2, timeout 6, transmit threshold 1, modem 0. When no source is pending, `irq_idle` is 1 and `irq_id` is 0.
- R10: `irq2_stat[0]` is receive-empty AND `en2_rx_empty`, and `irq2_stat[1]` is transmit-empty AND `en2_tx_empty`. `irq` is 1 when `irq_idle` is 0 or either `irq2_stat` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_din | input | 8 | Received byte |
| rx_din_pe | input | 1 | Parity error on the received byte |
| rx_din_fe | input | 1 | Framing error on the received byte |
| rx_din_brk | input | 1 | Break condition on the received byte |
| rx_pop | input | 1 | CPU reads the head receive byte |
| rx_dout | output | 8 | Head receive byte |
| rx_head_pe | output | 1 | Parity flag of the head byte |
| rx_head_fe | output | 1 | Framing flag of the head byte |
| rx_head_brk | output | 1 | Break flag of the head byte |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| tx_push | input | 1 | CPU writes a transmit byte |
| tx_din | input | 8 | Transmit byte |
| tx_pop | input | 1 | Transmit shifter takes the head byte |
| tx_dout | output | 8 | Head transmit byte |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| rx_trig_sel | input | 3 | Receive trigger level code |
| tx_trig_sel | input | 3 | Transmit trigger level code |
| en_line | input | 1 | Enable for the line error source |
| en_rx | input | 1 | Enable for the receive threshold and timeout sources |
| en_tx | input | 1 | Enable for the transmit threshold source |
| en_modem | input | 1 | Enable for the modem source |
| en2_rx_empty | input | 1 | Secondary enable, receive FIFO empty |
| en2_tx_empty | input | 1 | Secondary enable, transmit FIFO empty |
| modem_req | input | 1 | Modem status request from outside |
| err_any | output | 1 | Some stored receive byte is errored |
| overrun | output | 1 | Receive byte dropped, sticky |
| irq_id | output | 4 | Identity of the highest pending source |
| irq_idle | output | 1 | No primary source pending |
| irq2_stat | output | 2 | Masked secondary empty status |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume that `rst_n` is held low for a few cycles before any strobe is driven. They also assume that the data, flag and strobe inputs change only between clock edges, never at the edge itself. The bench drives every input one time unit after a rising edge and samples one time unit after the next edge, so each stimulus cycle is seen whole. Random traffic pushes on full FIFOs and pops on empty ones on purpose, because the assertions and requirements define both cases. The enables and trigger selects change only between stimulus phases, never in the middle of a cycle.

// File: rtl/uart_fifo_irq_pkg.sv
package uart_fifo_irq_pkg;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'd0,
    ID_TX_THR  = 4'd1,
    ID_RX_THR  = 4'd2,
    ID_LINE    = 4'd3,
    ID_TIMEOUT = 4'd6
  } irq_id_e;

  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } rx_err_t;

  // receive trigger level in bytes held
  function automatic int unsigned rx_trig_level(input logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 8;
      3'd2:    return 16;
      3'd3:    return 56;
      3'd4:    return 60;
      default: return 8;
    endcase
  endfunction

  // transmit trigger level in free spaces
  function automatic int unsigned tx_trig_level(input logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 8;
      3'd2:    return 16;
      3'd3:    return 32;
      3'd4:    return 56;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty,
  output logic                       push_ok,
  output logic                       pop_ok
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_full_push_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(wr_ptr)));

endmodule

// File: rtl/char_timer.sv
module char_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic has_data,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (restart || !has_data) cnt <= '0;
    else if (cnt != TW'(LIMIT))   cnt <= cnt + 1'b1;
  end

  assign expired = has_data && (cnt == TW'(LIMIT));

  p_tmo_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> $past(!restart));

endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import uart_fifo_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_p,
  input  logic       rxthr_p,
  input  logic       tmo_p,
  input  logic       txthr_p,
  input  logic       modem_p,
  output logic [3:0] id,
  output logic       idle
);
  always_comb begin
    idle = 1'b0;
    if      (line_p)  id = ID_LINE;
    else if (rxthr_p) id = ID_RX_THR;
    else if (tmo_p)   id = ID_TIMEOUT;
    else if (txthr_p) id = ID_TX_THR;
    else if (modem_p) id = ID_MODEM;
    else begin
      id   = 4'd0;
      idle = 1'b1;
    end
  end

  p_line_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_p |-> (id == 4'd3 && !idle));

  p_idle_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !(line_p || rxthr_p || tmo_p || txthr_p || modem_p));

endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import uart_fifo_irq_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int CHAR_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_push,
  input  logic [7:0] rx_din,
  input  logic       rx_din_pe,
  input  logic       rx_din_fe,
  input  logic       rx_din_brk,
  input  logic       rx_pop,
  output logic [7:0] rx_dout,
  output logic       rx_head_pe,
  output logic       rx_head_fe,
  output logic       rx_head_brk,
  output logic       rx_empty,
  output logic       rx_full,
  input  logic       tx_push,
  input  logic [7:0] tx_din,
  input  logic       tx_pop,
  output logic [7:0] tx_dout,
  output logic       tx_empty,
  output logic       tx_full,
  input  logic [2:0] rx_trig_sel,
  input  logic [2:0] tx_trig_sel,
  input  logic       en_line,
  input  logic       en_rx,
  input  logic       en_tx,
  input  logic       en_modem,
  input  logic       en2_rx_empty,
  input  logic       en2_tx_empty,
  input  logic       modem_req,
  output logic       err_any,
  output logic       overrun,
  output logic [3:0] irq_id,
  output logic       irq_idle,
  output logic [1:0] irq2_stat,
  output logic       irq
);
  localparam int CW        = $clog2(DEPTH) + 1;
  localparam int TMO_LIMIT = 4 * CHAR_CYCLES;
  localparam int RXW       = 8 + $bits(rx_err_t);

  // receive path
  rx_err_t        in_err, head_err;
  logic [RXW-1:0] rx_word, rx_head;
  logic [CW-1:0]  rx_count, tx_count, err_cnt;
  logic           rx_push_ok, rx_pop_ok, tx_push_ok, tx_pop_ok;
  logic           in_bad, head_bad;

  assign in_err  = '{brk: rx_din_brk, fe: rx_din_fe, pe: rx_din_pe};
  assign rx_word = {in_err, rx_din};

  byte_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop), .din(rx_word),
    .dout(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok));

  assign head_err    = rx_err_t'(rx_head[RXW-1:8]);
  assign rx_dout     = rx_head[7:0];
  assign rx_head_pe  = head_err.pe;
  assign rx_head_fe  = head_err.fe;
  assign rx_head_brk = head_err.brk;

  // count of errored entries held; summary follows it
  assign in_bad   = |in_err;
  assign head_bad = |head_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_cnt <= '0;
    else case ({rx_push_ok && in_bad, rx_pop_ok && head_bad})
      2'b10:   err_cnt <= err_cnt + 1'b1;
      2'b01:   err_cnt <= err_cnt - 1'b1;
      default: err_cnt <= err_cnt;
    endcase
  end
  assign err_any = (err_cnt != '0);

  // overrun: dropped push sets, accepted pop clears, set wins
  logic rx_drop;
  assign rx_drop = rx_push && rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         overrun <= 1'b0;
    else if (rx_drop)   overrun <= 1'b1;
    else if (rx_pop_ok) overrun <= 1'b0;
  end

  // transmit path
  byte_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop), .din(tx_din),
    .dout(tx_dout), .count(tx_count), .full(tx_full), .empty(tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok));

  // character timer
  logic tmo_evt;
  char_timer #(.LIMIT(TMO_LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(rx_push_ok || rx_pop_ok),
    .has_data(!rx_empty), .expired(tmo_evt));

  // pending sources
  logic rx_thr_hit, tx_thr_hit;
  logic line_p, rxthr_p, tmo_p, txthr_p, modem_p;

  assign rx_thr_hit = 32'(rx_count) >= rx_trig_level(rx_trig_sel);
  assign tx_thr_hit = 32'(tx_count) + tx_trig_level(tx_trig_sel) <= 32'(DEPTH);

  assign line_p  = en_line && (err_any || overrun);
  assign rxthr_p = en_rx && rx_thr_hit;
  assign tmo_p   = en_rx && tmo_evt;
  assign txthr_p = en_tx && tx_thr_hit;
  assign modem_p = en_modem && modem_req;

  irq_prio u_prio (
    .clk(clk), .rst_n(rst_n), .line_p(line_p), .rxthr_p(rxthr_p),
    .tmo_p(tmo_p), .txthr_p(txthr_p), .modem_p(modem_p),
    .id(irq_id), .idle(irq_idle));

  assign irq2_stat = {tx_empty && en2_tx_empty, rx_empty && en2_rx_empty};
  assign irq       = !irq_idle || (|irq2_stat);

  p_drop_sets_ovr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> overrun);

  p_err_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> !err_any);

  p_line_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_line && overrun) |-> irq);

endmodule

// File: tb/sim_uart_fifo_irq.sv
module sim_uart_fifo_irq;
  localparam int DEPTH = 64;
  localparam int CHARC = 16;
  localparam int LIMIT = 4 * CHARC;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       rx_push = 0, rx_din_pe = 0, rx_din_fe = 0, rx_din_brk = 0, rx_pop = 0;
  logic [7:0] rx_din = 0, tx_din = 0;
  logic       tx_push = 0, tx_pop = 0;
  logic [2:0] rx_trig_sel = 3'd1, tx_trig_sel = 3'd1;
  logic       en_line = 0, en_rx = 0, en_tx = 0, en_modem = 0;
  logic       en2_rx_empty = 0, en2_tx_empty = 0, modem_req = 0;
  logic [7:0] rx_dout, tx_dout;
  logic       rx_head_pe, rx_head_fe, rx_head_brk, rx_empty, rx_full;
  logic       tx_empty, tx_full, err_any, overrun, irq_idle, irq;
  logic [3:0] irq_id;
  logic [1:0] irq2_stat;

  uart_fifo_irq #(.DEPTH(DEPTH), .CHAR_CYCLES(CHARC)) u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [10:0] rxq[$];
  logic [7:0]  txq[$];
  bit          m_ovr = 0;
  int          tcnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rx_lvl(input logic [2:0] s);
    int t[8] = '{1, 8, 16, 56, 60, 8, 8, 8};
    return t[s];
  endfunction
  function automatic int tx_lvl(input logic [2:0] s);
    int t[8] = '{1, 8, 16, 32, 56, 8, 8, 8};
    return t[s];
  endfunction

  function automatic bit m_err();
    foreach (rxq[i]) if (rxq[i][10:8] != 0) return 1;
    return 0;
  endfunction

  // expected identity: scan sources from most to least urgent
  function automatic int exp_code(output bit idle);
    bit p[5];
    int c[5] = '{3, 2, 6, 1, 0};
    p[0] = en_line && (m_err() || m_ovr);
    p[1] = en_rx && rxq.size() >= rx_lvl(rx_trig_sel);
    p[2] = en_rx && rxq.size() > 0 && tcnt == LIMIT;
    p[3] = en_tx && (DEPTH - txq.size()) >= tx_lvl(tx_trig_sel);
    p[4] = en_modem && modem_req;
    for (int k = 0; k < 5; k++) if (p[k]) begin idle = 0; return c[k]; end
    idle = 1;
    return 0;
  endfunction

  task automatic compare_all();
    bit ei; int ec;
    chk(rx_empty == (rxq.size() == 0), "R1 rx_empty", rx_empty, rxq.size() == 0);
    chk(rx_full == (rxq.size() == DEPTH), "R1 rx_full", rx_full, rxq.size() == DEPTH);
    chk(tx_full == (txq.size() == DEPTH), "R3 tx_full", tx_full, txq.size() == DEPTH);
    chk(tx_empty == (txq.size() == 0), "R1 tx_empty", tx_empty, txq.size() == 0);
    if (rxq.size() > 0)
      chk({rx_head_brk, rx_head_fe, rx_head_pe, rx_dout} == rxq[0], "R7 rx head", 
          {rx_head_brk, rx_head_fe, rx_head_pe, rx_dout}, rxq[0]);
    if (txq.size() > 0) chk(tx_dout == txq[0], "R7 tx head", tx_dout, txq[0]);
    chk(overrun == m_ovr, "R2 overrun", overrun, m_ovr);
    chk(err_any == m_err(), "R6 err_any", err_any, m_err());
    ec = exp_code(ei);
    chk(irq_idle == ei, "R9 irq_idle", irq_idle, ei);
    chk(irq_id == 4'(ec), "R9 irq_id", irq_id, ec);
    chk(irq2_stat == {en2_tx_empty && txq.size() == 0, en2_rx_empty && rxq.size() == 0},
        "R10 irq2_stat", irq2_stat,
        {en2_tx_empty && txq.size() == 0, en2_rx_empty && rxq.size() == 0});
    chk(irq == (!ei || (|irq2_stat)), "R10 irq", irq, !ei);
  endtask

  task automatic step(input bit rp, input [7:0] rd, input [2:0] rf, input bit rpop,
                      input bit tp, input [7:0] td, input bit tpop);
    bit rfull, rempty, tfull, tempty, racc, rpacc;
    rx_push = rp; rx_din = rd; {rx_din_brk, rx_din_fe, rx_din_pe} = rf; rx_pop = rpop;
    tx_push = tp; tx_din = td; tx_pop = tpop;
    rfull = rxq.size() == DEPTH; rempty = rxq.size() == 0;
    tfull = txq.size() == DEPTH; tempty = txq.size() == 0;
    racc = rp && !rfull; rpacc = rpop && !rempty;
    @(posedge clk);
    if (racc || rpacc || rempty) tcnt = 0;
    else if (tcnt < LIMIT) tcnt++;
    if (rpacc) void'(rxq.pop_front());
    if (racc) rxq.push_back({rf, rd});
    if (rp && rfull) m_ovr = 1;
    else if (rpacc) m_ovr = 0;
    if (tpop && !tempty) void'(txq.pop_front());
    if (tp && !tfull) txq.push_back(td);
    #1;
    compare_all();
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(rx_empty && tx_empty && !rx_full && !tx_full, "R1 reset empty", rx_empty, 1);
    chk(!overrun && !err_any && irq_idle, "R1 reset flags", {overrun, err_any, irq_idle}, 1);
    rst_n = 1;
    @(posedge clk); #1;

    // R2: fill rx to 64, then drop one
    en_line = 1;
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i), 0, 0, 0, 0, 0);
    chk(rx_full == 1, "R1 full after 64", rx_full, 1);
    step(1, 8'hEE, 3'b001, 0, 0, 0, 0);
    chk(overrun == 1 && irq_id == 4'd3, "R2 drop sets overrun", irq_id, 3);
    step(1, 8'hEF, 0, 1, 0, 0, 0);
    chk(overrun == 1, "R2 set wins over clear", overrun, 1);
    step(0, 0, 0, 1, 0, 0, 0);
    chk(overrun == 0, "R2 pop clears", overrun, 0);
    while (rxq.size() > 0) step(0, 0, 0, 1, 0, 0, 0);

    // R6: errored byte in the middle stays flagged until popped
    step(1, 8'h11, 0, 0, 0, 0, 0);
    step(1, 8'h22, 3'b010, 0, 0, 0, 0);
    step(1, 8'h33, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    chk(err_any == 1, "R6 sticky while held", err_any, 1);
    step(0, 0, 0, 1, 0, 0, 0);
    chk(err_any == 0, "R6 clears after pop", err_any, 0);
    step(0, 0, 0, 1, 0, 0, 0);

    // R8: timeout
    en_line = 0; en_rx = 1; rx_trig_sel = 3'd4;
    step(1, 8'h44, 0, 0, 0, 0, 0);
    idle_n(LIMIT - 2);
    chk(irq_idle == 1, "R8 not yet", irq_idle, 1);
    idle_n(4);
    chk(irq_id == 4'd6 && !irq_idle, "R8 timeout fires", irq_id, 6);
    step(0, 0, 0, 1, 0, 0, 0);
    chk(irq_idle == 1, "R8 read clears", irq_idle, 0);

    // R4: each receive level
    for (int s = 0; s < 8; s++) begin
      rx_trig_sel = 3'(s);
      for (int i = 0; i < rx_lvl(3'(s)) - 1; i++) step(1, 8'(i), 0, 0, 0, 0, 0);
      chk(irq_idle == 1, "R4 below level", irq_idle, 1);
      step(1, 8'hA5, 0, 0, 0, 0, 0);
      chk(irq_id == 4'd2 && !irq_idle, "R4 at level", irq_id, 2);
      while (rxq.size() > 0) step(0, 0, 0, 1, 0, 0, 0);
    end
    en_rx = 0;

    // R5 and R3: each transmit level, then overfill
    en_tx = 1;
    for (int s = 0; s < 8; s++) begin
      tx_trig_sel = 3'(s);
      while (txq.size() < DEPTH - tx_lvl(3'(s))) step(0, 0, 0, 0, 1, 8'($urandom), 0);
      chk(irq_id == 4'd1 && !irq_idle, "R5 space at level", irq_id, 1);
      step(0, 0, 0, 0, 1, 8'h5A, 0);
      chk(irq_idle == 1, "R5 space below level", irq_idle, 1);
      while (txq.size() > 0) step(0, 0, 0, 0, 0, 0, 1);
    end
    while (txq.size() < DEPTH) step(0, 0, 0, 0, 1, 8'($urandom), 0);
    step(0, 0, 0, 0, 1, 8'hFF, 0);
    chk(tx_full == 1 && tx_dout == txq[0], "R3 push on full ignored", tx_dout, txq[0]);
    while (txq.size() > 0) step(0, 0, 0, 0, 0, 0, 1);

    // R10: secondary empties
    en2_rx_empty = 1; en2_tx_empty = 1; en_tx = 0;
    step(0, 0, 0, 0, 0, 0, 0);
    chk(irq2_stat == 2'b11 && irq == 1, "R10 both empty", irq2_stat, 3);
    en2_rx_empty = 0; en2_tx_empty = 0;

    // random phases
    for (int ph = 0; ph < 12; ph++) begin
      int pr = $urandom_range(1, 9), pp = $urandom_range(1, 9);
      {en_line, en_rx, en_tx, en_modem, en2_rx_empty, en2_tx_empty} = 6'($urandom);
      rx_trig_sel = 3'($urandom); tx_trig_sel = 3'($urandom); modem_req = 1'($urandom);
      for (int i = 0; i < 300; i++)
        step($urandom_range(0, 9) < pr, 8'($urandom),
             ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'd0,
             $urandom_range(0, 9) < pp, $urandom_range(0, 9) < pr, 8'($urandom),
             $urandom_range(0, 9) < pp);
      idle_n($urandom_range(0, LIMIT + 4));
    end

    done = 1;
    finish_run();
  end
endmodule